// File: doc/BRIEF.md
# Current-Mode PWM Gate Enable Controller

This block is the digital core of a single-ended switching converter's gate-drive path. It receives the oscillator waveform, the peak-current and current-limit comparator outputs, and a supply-good flag, all as asynchronous digital levels. It also receives two active-low override inputs: a shutdown request and a latch clear. It produces one gate-enable level for the external driver. The oscillator is divided by two, so a switching cycle spans two oscillator periods. The gate turns on when the divided clock rises and turns off no later than when it falls. This keeps the duty cycle at or below one half.

Within a cycle, a comparator trip ends the pulse early, and the pulse stays off until the next cycle starts. The shutdown input forces the gate off on its own. Holding shutdown and clear low together arms a hold latch, which keeps the gate off until the clear input returns high. While supply is not good, the divider and both latches are held cleared. The first pulse after the supply comes good therefore starts on a clean cycle boundary.

Every input passes through a synchronizer of `SYNC_STAGES` flops before it is used. The oscillator rising edge is found after synchronization. The shutdown and clear synchronizers come out of reset reading high, which is the idle state of both inputs.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: Switching cycles alternate with oscillator rising edges. The gate can only turn on at every second synchronized oscillator rising edge counted from supply-good, and the edges in between only end a cycle.
- R2: On a cycle-start edge with no trip active, the gate goes high exactly SYNC_STAGES+1 clocks after the oscillator input rises.
- R3: A peak-current trip (peak_trip=1) drives the gate low SYNC_STAGES clocks after it asserts. The gate stays low for the rest of that cycle even after the trip clears.
- R4: A current-limit trip (ilim_trip=1) behaves like R3: the gate goes low SYNC_STAGES clocks after it asserts and stays low for the rest of the cycle.
- R5: A trip that is already active when a cycle starts suppresses that cycle's pulse entirely.
- R6: An on-pulse ends at the next synchronized oscillator rising edge (gate low SYNC_STAGES+1 clocks after that rise), so on-time never exceeds half a switching period.
- R7: shutdown_n=0 forces the gate low SYNC_STAGES clocks later, regardless of the other inputs.
- R8: With shutdown_n=0 and latch_clr_n=1 the shutdown is not held. The gate resumes SYNC_STAGES clocks after shutdown_n returns to 1 if the pulse is still within its on-window.
- R9: shutdown_n=0 together with latch_clr_n=0 sets the hold latch. Afterwards shutdown_n=1 has no effect while latch_clr_n stays 0. latch_clr_n=1 clears the latch, and the gate resumes SYNC_STAGES+1 clocks after that rise.
- R10: With shutdown_n=1, latch_clr_n=0 and the latch not set, the gate operates normally.
- R11: While uv_good=0 the gate is low, and the divider and both latches are cleared. The first oscillator rise after uv_good=1 starts a cycle.
- R12: While rst_n=0 the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock, much faster than the oscillator |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Oscillator waveform, asynchronous |
| peak_trip | input | 1 | Peak-current comparator trip, high = tripped |
| ilim_trip | input | 1 | Current-limit comparator trip, high = tripped |
| uv_good | input | 1 | Supply above lockout threshold, high = good |
| shutdown_n | input | 1 | Active-low shutdown request |
| latch_clr_n | input | 1 | Active-low clear; low together with shutdown arms the hold latch |
| gate_en | output | 1 | Gate-drive enable |

## Verification
Two collisions are provoked deliberately. The first is a cycle-start edge arriving while a comparator trip is still active. The trip is raised before the oscillator rise and released while the on-window is still open. The gate must stay low through the release, which shows that the start edge lost to the trip instead of merely being masked. The second collision is the hold latch being armed while the pulse latch is set mid-cycle, then released before the cycle ends. The gate must come back in the exact clock after the latch clears and drop in the exact clock the divided clock falls.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  // Next state of the pulse latch. A cycle start wins over everything,
  // but a trip present at that moment suppresses the pulse.
  function automatic logic pwm_next(logic q, logic start, logic stop, logic trip);
    logic n;
    if (start)            n = ~trip;
    else if (stop | trip) n = 1'b0;
    else                  n = q;
    return n;
  endfunction

  // Next state of the hold latch for the shutdown / clear pair.
  function automatic logic hold_next(logic q, logic sd_n, logic clr_n);
    logic n;
    if (!sd_n && !clr_n) n = 1'b1;
    else if (clr_n)      n = 1'b0;
    else                 n = q;
    return n;
  endfunction

  // Final gate qualification.
  function automatic logic gate_qual(logic pwm, logic trip, logic sd_n,
                                     logic hold, logic good);
    return pwm & ~trip & sd_n & ~hold & good;
  endfunction

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwm_divider.sv
module pwm_divider (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic osc_s,
  output logic phase,
  output logic cycle_start,
  output logic cycle_end
);
  logic osc_prev;
  logic tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_prev <= 1'b0;
    else        osc_prev <= osc_s;
  end

  assign tick = osc_s & ~osc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= 1'b0;
    else if (!en)   phase <= 1'b0;
    else if (tick)  phase <= ~phase;
  end

  assign cycle_start = en & tick & ~phase;
  assign cycle_end   = en & tick &  phase;
endmodule

// File: rtl/pwm_pulse_latch.sv
module pwm_pulse_latch
  import pwm_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic stop,
  input  logic trip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (!en) q <= 1'b0;
    else          q <= pwm_next(q, start, stop, trip);
  end
endmodule

// File: rtl/pwm_hold_latch.sv
module pwm_hold_latch
  import pwm_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sd_n,
  input  logic clr_n,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (!en) q <= 1'b0;
    else          q <= hold_next(q, sd_n, clr_n);
  end
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  input  logic peak_trip,
  input  logic ilim_trip,
  input  logic uv_good,
  input  logic shutdown_n,
  input  logic latch_clr_n,
  output logic gate_en
);
  localparam int unsigned NIN = 6;
  // bit order: clr, shutdown, uv, ilim, peak, osc
  localparam logic [NIN-1:0] SYNC_RST = 6'b110000;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] sync_in;

  logic s_osc, s_peak, s_ilim, s_uv, s_sd_n, s_clr_n;
  logic trip_any;
  logic div_phase, cycle_start, cycle_end;
  logic pwm_q, hold_q;

  assign raw_in = {latch_clr_n, shutdown_n, uv_good, ilim_trip, peak_trip, osc_in};

  pwm_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  assign s_osc   = sync_in[0];
  assign s_peak  = sync_in[1];
  assign s_ilim  = sync_in[2];
  assign s_uv    = sync_in[3];
  assign s_sd_n  = sync_in[4];
  assign s_clr_n = sync_in[5];

  assign trip_any = s_peak | s_ilim;

  pwm_divider u_div (
    .clk(clk), .rst_n(rst_n), .en(s_uv), .osc_s(s_osc),
    .phase(div_phase), .cycle_start(cycle_start), .cycle_end(cycle_end)
  );

  pwm_pulse_latch u_pulse (
    .clk(clk), .rst_n(rst_n), .en(s_uv), .start(cycle_start),
    .stop(cycle_end), .trip(trip_any), .q(pwm_q)
  );

  pwm_hold_latch u_hold (
    .clk(clk), .rst_n(rst_n), .en(s_uv), .sd_n(s_sd_n),
    .clr_n(s_clr_n), .q(hold_q)
  );

  assign gate_en = gate_qual(pwm_q, trip_any, s_sd_n, hold_q, s_uv);
endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic s_peak,
  input logic s_ilim,
  input logic s_uv,
  input logic s_sd_n,
  input logic s_clr_n,
  input logic div_phase,
  input logic cycle_start,
  input logic cycle_end,
  input logic pwm_q,
  input logic hold_q,
  input logic gate_en
);
  // R1
  start_sets_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> div_phase);
  // R1
  end_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !div_phase);
  // R2
  pulse_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> $past(cycle_start));
  // R3
  peak_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_peak && !cycle_start) |=> !pwm_q);
  // R4
  ilim_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ilim && !cycle_start) |=> !pwm_q);
  // R5
  trip_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && (s_peak || s_ilim)) |=> !pwm_q);
  // R6
  duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en |-> div_phase);
  // R8
  clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_clr_n |=> !hold_q);
  // R9
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_sd_n && !s_clr_n && s_uv) |=> hold_q);
  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !s_clr_n && s_uv) |=> hold_q);
  // R11
  uv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_uv |=> (!div_phase && !pwm_q && !hold_q));
endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_peak(s_peak), .s_ilim(s_ilim), .s_uv(s_uv),
  .s_sd_n(s_sd_n), .s_clr_n(s_clr_n), .div_phase(div_phase),
  .cycle_start(cycle_start), .cycle_end(cycle_end), .pwm_q(pwm_q),
  .hold_q(hold_q), .gate_en(gate_en)
);

// File: tb/pwm_gate_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_gate_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_in = 1'b0, peak_trip = 1'b0, ilim_trip = 1'b0, uv_good = 1'b0;
  logic shutdown_n = 1'b1, latch_clr_n = 1'b1;
  logic gate_en;

  typedef struct { int at; logic val; string tag; } exp_t;
  exp_t sb[$];
  exp_t mon_e;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_gate_ctrl u_pwm_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .peak_trip(peak_trip),
    .ilim_trip(ilim_trip), .uv_good(uv_good), .shutdown_n(shutdown_n),
    .latch_clr_n(latch_clr_n), .gate_en(gate_en)
  );

  // driver side: expected gate value at a cycle relative to now
  task automatic expect_at(int ofs, logic v, string tag);
    exp_t e;
    int i;
    e.at = cyc + ofs; e.val = v; e.tag = tag;
    i = 0;
    while (i < sb.size() && sb[i].at <= e.at) i++;
    sb.insert(i, e);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic osc_pulse();
    osc_in = 1'b1; wait_n(4);
    osc_in = 1'b0; wait_n(4);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      mon_e = sb.pop_front();
      n_chk++;
      if (mon_e.at != cyc || gate_en !== mon_e.val) begin
        n_fail++;
        $display("FAIL %s cycle %0d: gate_en actual %b expected %b",
                 mon_e.tag, mon_e.at, gate_en, mon_e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R12 reset state
    expect_at(2, 1'b0, "R12"); expect_at(4, 1'b0, "R12");
    wait_n(5); rst_n = 1'b1; wait_n(2);

    // R11 no pulse before supply good
    expect_at(3, 1'b0, "R11"); expect_at(6, 1'b0, "R11");
    osc_pulse();
    uv_good = 1'b1; wait_n(4);

    // R1 R2 R6 normal cycles
    expect_at(2, 1'b0, "R2");  expect_at(3, 1'b1, "R2");
    expect_at(10, 1'b1, "R6"); expect_at(11, 1'b0, "R6");
    expect_at(15, 1'b0, "R1"); expect_at(18, 1'b0, "R1");
    expect_at(19, 1'b1, "R1"); expect_at(26, 1'b1, "R6");
    expect_at(27, 1'b0, "R6");
    repeat (4) osc_pulse();

    // R3 peak trip mid-pulse
    expect_at(3, 1'b1, "R3"); expect_at(5, 1'b1, "R3");
    expect_at(6, 1'b0, "R3"); expect_at(7, 1'b0, "R3");
    expect_at(9, 1'b0, "R3"); expect_at(12, 1'b0, "R3");
    osc_in = 1'b1; wait_n(4); osc_in = 1'b0; peak_trip = 1'b1; wait_n(2);
    peak_trip = 1'b0; wait_n(2); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(4);

    // R4 current-limit trip mid-pulse
    expect_at(3, 1'b1, "R4"); expect_at(5, 1'b1, "R4");
    expect_at(6, 1'b0, "R4"); expect_at(9, 1'b0, "R4");
    osc_in = 1'b1; wait_n(4); osc_in = 1'b0; ilim_trip = 1'b1; wait_n(2);
    ilim_trip = 1'b0; wait_n(2); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(4);

    // R5 trip active at cycle start
    expect_at(6, 1'b0, "R5"); expect_at(8, 1'b0, "R5");
    expect_at(10, 1'b0, "R5"); expect_at(12, 1'b0, "R5");
    peak_trip = 1'b1; wait_n(3); osc_in = 1'b1; wait_n(4); osc_in = 1'b0;
    peak_trip = 1'b0; wait_n(4); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(4);

    // R7 R8 unlatched shutdown
    expect_at(5, 1'b1, "R7"); expect_at(6, 1'b0, "R7");
    expect_at(7, 1'b0, "R7"); expect_at(8, 1'b1, "R8");
    expect_at(9, 1'b1, "R8"); expect_at(11, 1'b0, "R6");
    osc_in = 1'b1; wait_n(4); osc_in = 1'b0; shutdown_n = 1'b0; wait_n(2);
    shutdown_n = 1'b1; wait_n(2); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(4);

    // R9 latched shutdown
    expect_at(9, 1'b0, "R9");  expect_at(12, 1'b0, "R9");
    expect_at(14, 1'b0, "R9"); expect_at(15, 1'b1, "R9");
    expect_at(18, 1'b1, "R9"); expect_at(19, 1'b0, "R9");
    shutdown_n = 1'b0; latch_clr_n = 1'b0; wait_n(3);
    shutdown_n = 1'b1; wait_n(3); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(2);
    latch_clr_n = 1'b1; wait_n(4); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(4);

    // R10 clear low alone does not stop the gate
    expect_at(6, 1'b1, "R10"); expect_at(13, 1'b1, "R10");
    expect_at(14, 1'b0, "R10");
    latch_clr_n = 1'b0; wait_n(3); osc_in = 1'b1; wait_n(4); osc_in = 1'b0; wait_n(4);
    osc_in = 1'b1; wait_n(4); osc_in = 1'b0; latch_clr_n = 1'b1; wait_n(4);

    // R11 supply loss mid-pulse resets the divider
    expect_at(5, 1'b1, "R11");  expect_at(6, 1'b0, "R11");
    expect_at(9, 1'b0, "R11");  expect_at(14, 1'b0, "R11");
    expect_at(15, 1'b1, "R11"); expect_at(22, 1'b1, "R11");
    expect_at(23, 1'b0, "R11");
    osc_in = 1'b1; wait_n(4); osc_in = 1'b0; uv_good = 1'b0; wait_n(4);
    uv_good = 1'b1; wait_n(4);
    osc_pulse(); osc_pulse();

    wait_n(5);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule